// File: doc/BRIEF.md
# UART Automatic Hardware Handshake Controller

This block sits beside a UART's transmit shifter and receive FIFO and runs the modem handshake lines without software help. On the send side it watches the clear-to-send input. When the far end raises that line, which asks this side to stop, the block withdraws its transmit permission. It does so only at a character boundary, so a character already on the wire always finishes through its stop bit. When the line falls again, permission returns.

On the receive side it drives request-to-send from the receive FIFO fill count. It uses two separate thresholds so that the line does not chatter. RTS goes inactive once occupancy climbs to the high level. It stays inactive until occupancy drains to the low level or below.

The thresholds come from one of two sources. In legacy mode a 2-bit code picks a fixed pair of levels. In extended mode two programmable level inputs supply them. The rising edge of the synchronised clear-to-send line can also latch an interrupt status bit, which a status read clears. All pins are plain level or strobe signals. No stream data passes through the block, so it has no valid/ready handshake.

Top module: `uart_autoflow`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `rts_n` is 0 (request asserted), `tx_permit` is 1 and `cts_irq` is 0.
- R2: With `auto_cts_en` low, `tx_permit` is 1 one cycle later, whatever `cts_pin`, `tx_busy` and `char_done` do.
- R3: With `auto_cts_en` high and `tx_busy` low, a change of `cts_pin` from 0 to 1 drops `tx_permit` three clock edges after the new pin value is sampled. The path is two synchroniser flops plus the permit register.
- R4: If `tx_busy` is high when the stop request takes effect, `tx_permit` stays 1 until `char_done` pulses. It falls on the edge that samples `char_done`, so the current character is never cut short.
- R5: When the synchronised CTS returns to 0, `tx_permit` returns to 1 on the next edge, which is three edges after the pin falls.
- R6: With `cts_irq_en` high, a synchronised rising edge of CTS sets `cts_irq` on the same edge that R3 names. With `cts_irq_en` low, a rising edge leaves `cts_irq` unchanged.
- R7: A `status_rd` pulse clears `cts_irq` on the next edge. If a new rising edge arrives in the same cycle, the set wins.
- R8: In legacy mode (`ext_mode` = 0), `rts_n` goes to 1 on the edge after `rx_count` is at or above the high level. `lvl_sel` codes 0, 1, 2 and 3 give high levels of 8, 16, 24 and 28.
- R9: In legacy mode, `rts_n` returns to 0 on the edge after `rx_count` is at or below the low level. `lvl_sel` codes 0, 1, 2 and 3 give low levels of 0, 7, 15 and 23.
- R10: While `rx_count` lies strictly between the low and high levels, `rts_n` holds its previous value.
- R11: With `ext_mode` = 1, `ext_hi` is the high level and `ext_lo` is the low level. The comparisons are the same as in R8 and R9.
- R12: With `auto_rts_en` low, `rts_n` is 0 one edge later, whatever `rx_count` is.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| auto_cts_en | input | 1 | Enables transmit gating from CTS |
| auto_rts_en | input | 1 | Enables RTS control from RX occupancy |
| cts_irq_en | input | 1 | Enables the CTS-rise status bit |
| cts_pin | input | 1 | Raw CTS line; 1 requests a stop |
| tx_busy | input | 1 | Shifter is sending a character |
| char_done | input | 1 | One-cycle strobe after the stop bit leaves |
| tx_permit | output | 1 | Shifter may start a new character |
| cts_irq | output | 1 | Latched CTS-rise status |
| status_rd | input | 1 | Status read strobe; clears `cts_irq` |
| ext_mode | input | 1 | 0 selects table levels, 1 selects programmed levels |
| lvl_sel | input | 2 | Legacy level-pair code |
| ext_hi | input | CNT_W | Programmed high (negate) level |
| ext_lo | input | CNT_W | Programmed low (re-assert) level |
| rx_count | input | CNT_W | RX FIFO occupancy |
| rts_n | output | 1 | RTS, active low |

## Verification
The results arrive with fixed latencies. `rts_n` follows `rx_count`, the enables and the levels after exactly one edge. `tx_permit` and `cts_irq` follow `cts_pin` after three edges. They follow `tx_busy`, `char_done`, `status_rd` and the enables after one edge. The bench reference model uses a short history queue of sampled CTS values to reproduce the three-edge delay. It updates on every rising edge from inputs that the bench changes only at falling edges. All three outputs are compared against the model at each falling edge. Directed checks count the edges explicitly before they sample the threshold boundaries, the busy hold and the read-versus-set collision.

// File: rtl/uaf_pkg.sv
package uaf_pkg;
  localparam int LVL_W = 8;

  function automatic logic [LVL_W-1:0] legacy_hi(input logic [1:0] code);
    case (code)
      2'd0:    legacy_hi = 8'd8;
      2'd1:    legacy_hi = 8'd16;
      2'd2:    legacy_hi = 8'd24;
      default: legacy_hi = 8'd28;
    endcase
  endfunction

  function automatic logic [LVL_W-1:0] legacy_lo(input logic [1:0] code);
    case (code)
      2'd0:    legacy_lo = 8'd0;
      2'd1:    legacy_lo = 8'd7;
      2'd2:    legacy_lo = 8'd15;
      default: legacy_lo = 8'd23;
    endcase
  endfunction
endpackage

// File: rtl/uaf_cts_sync.sv
module uaf_cts_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic level,
  output logic rise
);
  logic [STAGES-1:0] chain;
  logic              prev;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[0] <= 1'b0;
          else        chain[0] <= pin;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[i] <= 1'b0;
          else        chain[i] <= chain[i-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) prev <= 1'b0;
    else        prev <= chain[STAGES-1];

  assign level = chain[STAGES-1];
  assign rise  = chain[STAGES-1] & ~prev;

  p_rise_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise);
endmodule

// File: rtl/uaf_tx_gate.sv
module uaf_tx_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic auto_en,
  input  logic stop_req,
  input  logic stop_rise,
  input  logic tx_busy,
  input  logic char_done,
  input  logic irq_en,
  input  logic status_rd,
  output logic tx_permit,
  output logic cts_irq
);
  logic permit_q, irq_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     permit_q <= 1'b1;
    else if (!auto_en || !stop_req) permit_q <= 1'b1;
    else if (!tx_busy || char_done) permit_q <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   irq_q <= 1'b0;
    else if (stop_rise && irq_en) irq_q <= 1'b1;
    else if (status_rd)           irq_q <= 1'b0;
  end

  assign tx_permit = permit_q;
  assign cts_irq   = irq_q;

  p_cts_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !auto_en |=> tx_permit);
  p_hold_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_permit && tx_busy && !char_done) |=> tx_permit);
  p_irq_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_rise && irq_en) |=> cts_irq);
  p_irq_clr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (status_rd && !(stop_rise && irq_en)) |=> !cts_irq);
  p_irq_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!cts_irq && !(stop_rise && irq_en)) |=> !cts_irq);
endmodule

// File: rtl/uaf_rts_hyst.sv
module uaf_rts_hyst
  import uaf_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             auto_en,
  input  logic             ext_mode,
  input  logic [1:0]       lvl_sel,
  input  logic [CNT_W-1:0] ext_hi,
  input  logic [CNT_W-1:0] ext_lo,
  input  logic [CNT_W-1:0] rx_count,
  output logic             rts_n
);
  localparam int W = (CNT_W > LVL_W) ? CNT_W : LVL_W;

  logic [W-1:0] hi_lvl, lo_lvl, cnt_w;
  logic         rts_q;

  always_comb begin
    cnt_w = W'(rx_count);
    if (ext_mode) begin
      hi_lvl = W'(ext_hi);
      lo_lvl = W'(ext_lo);
    end else begin
      hi_lvl = W'(legacy_hi(lvl_sel));
      lo_lvl = W'(legacy_lo(lvl_sel));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                rts_q <= 1'b0;
    else if (!auto_en)         rts_q <= 1'b0;
    else if (cnt_w >= hi_lvl)  rts_q <= 1'b1;
    else if (cnt_w <= lo_lvl)  rts_q <= 1'b0;
  end

  assign rts_n = rts_q;

  p_rts_off_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !auto_en |=> !rts_n);
  p_hold_band_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_en && cnt_w > lo_lvl && cnt_w < hi_lvl) |=> $stable(rts_n));
  p_legacy_neg_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_en && !ext_mode && lvl_sel == 2'd0 && cnt_w >= W'(8)) |=> rts_n);
endmodule

// File: rtl/uart_autoflow.sv
module uart_autoflow
  import uaf_pkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             auto_cts_en,
  input  logic             auto_rts_en,
  input  logic             cts_irq_en,
  input  logic             cts_pin,
  input  logic             tx_busy,
  input  logic             char_done,
  output logic             tx_permit,
  output logic             cts_irq,
  input  logic             status_rd,
  input  logic             ext_mode,
  input  logic [1:0]       lvl_sel,
  input  logic [CNT_W-1:0] ext_hi,
  input  logic [CNT_W-1:0] ext_lo,
  input  logic [CNT_W-1:0] rx_count,
  output logic             rts_n
);
  logic cts_lvl, cts_rise;

  uaf_cts_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .pin(cts_pin), .level(cts_lvl), .rise(cts_rise)
  );

  uaf_tx_gate u_gate (
    .clk(clk), .rst_n(rst_n), .auto_en(auto_cts_en), .stop_req(cts_lvl),
    .stop_rise(cts_rise), .tx_busy(tx_busy), .char_done(char_done),
    .irq_en(cts_irq_en), .status_rd(status_rd),
    .tx_permit(tx_permit), .cts_irq(cts_irq)
  );

  uaf_rts_hyst #(.CNT_W(CNT_W)) u_rts (
    .clk(clk), .rst_n(rst_n), .auto_en(auto_rts_en), .ext_mode(ext_mode),
    .lvl_sel(lvl_sel), .ext_hi(ext_hi), .ext_lo(ext_lo),
    .rx_count(rx_count), .rts_n(rts_n)
  );

  p_resume_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_cts_en && !cts_lvl) |=> tx_permit);
endmodule

// File: tb/uart_autoflow_tb.sv
module uart_autoflow_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic auto_cts_en = 0, auto_rts_en = 0, cts_irq_en = 0, cts_pin = 0;
  logic tx_busy = 0, char_done = 0, status_rd = 0, ext_mode = 0;
  logic [1:0] lvl_sel = 0;
  logic [7:0] ext_hi = 0, ext_lo = 0, rx_count = 0;
  logic tx_permit, cts_irq, rts_n;

  int n_run = 0, n_fail = 0, cyc = 0;
  bit cmp_on = 0;

  always #5 clk = ~clk;

  uart_autoflow u_dut (
    .clk(clk), .rst_n(rst_n), .auto_cts_en(auto_cts_en), .auto_rts_en(auto_rts_en),
    .cts_irq_en(cts_irq_en), .cts_pin(cts_pin), .tx_busy(tx_busy),
    .char_done(char_done), .tx_permit(tx_permit), .cts_irq(cts_irq),
    .status_rd(status_rd), .ext_mode(ext_mode), .lvl_sel(lvl_sel),
    .ext_hi(ext_hi), .ext_lo(ext_lo), .rx_count(rx_count), .rts_n(rts_n)
  );

  // behavioural reference model
  bit hist[$];
  bit m_permit = 1, m_irq = 0, m_rts = 0;
  int hi_tab[4] = '{8, 16, 24, 28};
  int lo_tab[4] = '{0, 7, 15, 23};

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist = '{0, 0, 0, 0};
      m_permit = 1; m_irq = 0; m_rts = 0;
    end else begin
      int hi, lo;
      bit req, rise;
      hist.push_front(cts_pin);
      void'(hist.pop_back());
      req  = hist[2];
      rise = hist[2] && !hist[3];
      if (!auto_cts_en || !req) m_permit = 1;
      else if (!tx_busy || char_done) m_permit = 0;
      if (rise && cts_irq_en) m_irq = 1;
      else if (status_rd) m_irq = 0;
      hi = ext_mode ? int'(ext_hi) : hi_tab[lvl_sel];
      lo = ext_mode ? int'(ext_lo) : lo_tab[lvl_sel];
      if (!auto_rts_en) m_rts = 0;
      else if (int'(rx_count) >= hi) m_rts = 1;
      else if (int'(rx_count) <= lo) m_rts = 0;
    end
  end

  task automatic chk(input bit act, input bit exp, input string tag);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s at cycle %0d: actual %0b expected %0b", tag, cyc, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (cmp_on) begin
      chk(rts_n, m_rts, ext_mode ? "R11 rts model" : (!auto_rts_en ? "R12 rts model" : "R10 rts model"));
      chk(tx_permit, m_permit, !auto_cts_en ? "R2 permit model" : "R4 permit model");
      chk(cts_irq, m_irq, "R6 irq model");
    end
    if (cyc > 100000) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    step(2);
    chk(rts_n, 1'b0, "R1 rts in reset");
    chk(tx_permit, 1'b1, "R1 permit in reset");
    chk(cts_irq, 1'b0, "R1 irq in reset");
    rst_n = 1'b1;
    step(1);
    chk(tx_permit, 1'b1, "R1 permit after reset");
    cmp_on = 1;

    // R2: gating off ignores CTS
    cts_pin = 1; step(5);
    chk(tx_permit, 1'b1, "R2 permit with auto off");
    cts_pin = 0; step(5);

    // R3: idle stop, three edges
    auto_cts_en = 1; cts_irq_en = 1;
    cts_pin = 1; step(2);
    chk(tx_permit, 1'b1, "R3 permit before 3rd edge");
    step(1);
    chk(tx_permit, 1'b0, "R3 permit after 3rd edge");
    chk(cts_irq, 1'b1, "R6 irq set on rise");

    // R7: read clears
    status_rd = 1; step(1); status_rd = 0;
    chk(cts_irq, 1'b0, "R7 irq cleared by read");

    // R5: resume
    cts_pin = 0; step(3);
    chk(tx_permit, 1'b1, "R5 permit after CTS fall");

    // R4: busy character finishes first
    tx_busy = 1; cts_pin = 1; step(6);
    chk(tx_permit, 1'b1, "R4 permit held while busy");
    char_done = 1; step(1); char_done = 0; tx_busy = 0;
    chk(tx_permit, 1'b0, "R4 permit drops after char_done");
    cts_pin = 0; step(4);

    // R7: collision, set wins
    cts_pin = 1; step(2); status_rd = 1; step(1); status_rd = 0;
    chk(cts_irq, 1'b1, "R7 set wins over read");
    status_rd = 1; step(1); status_rd = 0;
    cts_pin = 0; step(4);

    // R6: disabled interrupt
    cts_irq_en = 0; cts_pin = 1; step(4);
    chk(cts_irq, 1'b0, "R6 irq stays low when disabled");
    cts_pin = 0; step(4);

    // R8 / R9 / R10 legacy levels
    auto_rts_en = 1;
    for (int s = 0; s < 4; s++) begin
      lvl_sel = 2'(s);
      rx_count = 8'(hi_tab[s] - 1); step(1);
      chk(rts_n, 1'b0, "R8 below high level");
      rx_count = 8'(hi_tab[s]); step(1);
      chk(rts_n, 1'b1, "R8 at high level");
      rx_count = 8'(lo_tab[s] + 1); step(1);
      chk(rts_n, 1'b1, "R10 held in band");
      rx_count = 8'(lo_tab[s]); step(1);
      chk(rts_n, 1'b0, "R9 at low level");
    end

    // R11 extended
    ext_mode = 1; ext_hi = 8'd100; ext_lo = 8'd40;
    rx_count = 8'd99; step(1); chk(rts_n, 1'b0, "R11 below ext_hi");
    rx_count = 8'd100; step(1); chk(rts_n, 1'b1, "R11 at ext_hi");
    rx_count = 8'd41; step(1); chk(rts_n, 1'b1, "R11 held above ext_lo");
    rx_count = 8'd40; step(1); chk(rts_n, 1'b0, "R11 at ext_lo");

    // R12
    rx_count = 8'd120; step(1);
    auto_rts_en = 0; step(1);
    chk(rts_n, 1'b0, "R12 rts with auto off");

    // random phase against the model
    for (int i = 0; i < 3000; i++) begin
      if ($urandom_range(0, 7) == 0) cts_pin = ~cts_pin;
      auto_cts_en = ($urandom_range(0, 15) != 0);
      auto_rts_en = ($urandom_range(0, 15) != 0);
      cts_irq_en  = $urandom_range(0, 1);
      tx_busy     = $urandom_range(0, 1);
      char_done   = ($urandom_range(0, 5) == 0);
      status_rd   = ($urandom_range(0, 4) == 0);
      if ($urandom_range(0, 63) == 0) ext_mode = ~ext_mode;
      if ($urandom_range(0, 63) == 0) lvl_sel = 2'($urandom_range(0, 3));
      rx_count = 8'($urandom_range(0, 130));
      step(1);
    end

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule